// File: doc/BRIEF.md
# Test-Mode Address Counter Sequencer

This block supplies test-mode sequencing for an embedded nonvolatile memory. Normally the array address comes from an external address register, and a rising edge of the load strobe loads that register. When the test-mode input is high, the strobe no longer loads that register. The address shown to the array is then an internal counter. A clear pulse sets the counter to all ones, and every rising edge of the increment input advances it by one. The first increment after a clear therefore selects address zero.

Writes are staged while the load input is high. Each strobe edge latches data toward the array page buffer. When load falls, the block commits the staged data in a single timed write. The write goes to the current page, to every even page, to every odd page, or to the whole array. A whole-array write fills every page with a single data bit. The page-enable vector tells a behavioural array model which pages take part. The busy output covers the timed write, and all test inputs are ignored while busy is high. A read-enable output tells the array to present the word at the current address.

Top module: `tmode_seq`

## Requirements
- R1: After reset, busy_o, lat_we_o, fill_o and page_we_o are 0, the external address register holds 0, and the counter holds all ones (7FFh with defaults).
- R2: With tst_mode_i high and busy_o low, clr_i high at a clock edge sets the counter to all ones. It takes priority over a coincident increment.
- R3: With tst_mode_i high and busy_o low, each 0-to-1 transition of incr_i adds one to the counter, whatever the length of the pulse. From all ones the counter wraps to 0, and in test mode addr_o shows the counter at all times.
- R4: With tst_mode_i low, addr_o shows the external address register, and a rising edge of strobe_i loads addr_i into it. In this mode clr_i and incr_i leave the counter unchanged.
- R5: With tst_mode_i high, a strobe_i rising edge does not load the external address register.
- R6: In test mode, while busy_o is low, a strobe_i rising edge with load_i high arms a commit. If blk_mode_i is low, lat_we_o is also high for exactly the following cycle, with wdata_o equal to din_i as sampled.
- R7: A falling edge of load_i in test mode with busy_o low and a commit armed makes busy_o high for exactly BUSY_CYC cycles, starting the next cycle. A load fall with nothing armed starts no write.
- R8: During a write with blk_mode_i, even_sel_i and odd_sel_i all low at the load fall, page_we_o is one-hot. The bit set is the page given by the address bits above OFF_W at the load fall.
- R9: With even_sel_i high, page_we_o sets every even-indexed bit. With odd_sel_i high, it sets every odd-indexed bit. With both high, it sets every bit.
- R10: With blk_mode_i high at the load fall, page_we_o is all ones and fill_o is high for the write, overriding even_sel_i and odd_sel_i. fill_val_o equals blk_data_i as sampled at the last arming strobe edge.
- R11: While busy_o is high, clr_i, incr_i, strobe_i and load_i falls have no effect. The counter holds, lat_we_o stays low, and the write is not extended.
- R12: rd_en_o is high exactly when tst_mode_i and rd_i are high and load_i and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_mode_i | input | 1 | Test mode select |
| clr_i | input | 1 | Counter preset to all ones |
| incr_i | input | 1 | Counter increment, rising edge |
| strobe_i | input | 1 | Address/data latch strobe, rising edge |
| load_i | input | 1 | Write staging; fall commits |
| rd_i | input | 1 | Read request |
| blk_mode_i | input | 1 | Whole-array fill write |
| blk_data_i | input | 1 | Fill value |
| even_sel_i | input | 1 | Replicate to even pages |
| odd_sel_i | input | 1 | Replicate to odd pages |
| addr_i | input | ADDR_W | External address |
| din_i | input | DATA_W | Write data |
| addr_o | output | ADDR_W | Array address |
| rd_en_o | output | 1 | Array read enable |
| lat_we_o | output | 1 | Page buffer latch pulse |
| wdata_o | output | DATA_W | Page buffer data |
| page_we_o | output | 2**(ADDR_W-OFF_W) | Per-page write enables during busy |
| fill_o | output | 1 | Whole-array fill in progress |
| fill_val_o | output | 1 | Fill bit value |
| busy_o | output | 1 | Timed write in progress |

## Verification
The assertions assume that all inputs are synchronous levels that change away from the active clock edge. They also assume that increment, strobe and load transitions are seen as one-cycle differences against their registered copies. The stimulus drives every input on the falling edge and holds it for at least one full cycle. A clear, an increment, a strobe and a load fall can therefore each be seen at the next rising edge. The stimulus keeps the mode selects (block, even, odd) steady from the first arming strobe until the write completes, since the assertions tie the enable pattern to the mode selects as they stand at the load fall.

// File: rtl/tmode_seq_pkg.sv
package tmode_seq_pkg;
  typedef enum logic [1:0] {
    WK_PAGE = 2'd0,
    WK_EVEN = 2'd1,
    WK_ODD  = 2'd2,
    WK_ALL  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/tmode_seq_edge.sv
module tmode_seq_edge #(
  parameter int W    = 1,
  parameter bit RISE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  if (RISE) begin : g_rise
    assign edge_o = sig_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~sig_i & prev_q;
  end
endmodule

// File: rtl/tmode_seq_addr.sv
module tmode_seq_addr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tst_i,
  input  logic              busy_i,
  input  logic              clr_i,
  input  logic              incr_rise_i,
  input  logic              strobe_rise_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q, areg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      areg_q <= '0;
    end else begin
      if (tst_i && !busy_i) begin
        if (clr_i)            cnt_q <= '1;
        else if (incr_rise_i) cnt_q <= cnt_q + 1'b1;
      end
      if (!tst_i && strobe_rise_i) areg_q <= ext_addr_i;
    end
  end

  assign addr_o = tst_i ? cnt_q : areg_q;

  // R2
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_i && !busy_i && clr_i |=> cnt_q == '1);
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_i && !busy_i && !clr_i && incr_rise_i && cnt_q == '1 |=> cnt_q == '0);
  // R11
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cnt_q));
  // R4
  ntst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tst_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmode_seq_commit.sv
module tmode_seq_commit
  import tmode_seq_pkg::*;
#(
  parameter int PAGE_W   = 6,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 20,
  localparam int NUM_PAGES = 1 << PAGE_W,
  localparam int BC_W      = $clog2(BUSY_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tst_i,
  input  logic                 load_i,
  input  logic                 strobe_rise_i,
  input  logic                 load_fall_i,
  input  logic                 blk_mode_i,
  input  logic                 blk_data_i,
  input  logic                 even_i,
  input  logic                 odd_i,
  input  logic [DATA_W-1:0]    din_i,
  input  logic [PAGE_W-1:0]    cur_page_i,
  output logic                 lat_we_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_PAGES-1:0] page_we_o,
  output logic                 fill_o,
  output logic                 fill_val_o,
  output logic                 busy_o
);
  logic [BC_W-1:0]   bcnt_q;
  logic              pend_q, blk_bit_q, fill_q, lat_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PAGE_W-1:0] page_q;
  wr_kind_e          kind_q, kind_d;
  logic              cap, commit;
  logic [NUM_PAGES-1:0] sel;

  assign busy_o = (bcnt_q != '0);
  assign cap    = tst_i && !busy_o && load_i && strobe_rise_i;
  assign commit = tst_i && !busy_o && load_fall_i && pend_q;

  always_comb begin
    unique case ({odd_i, even_i})
      2'b11:   kind_d = WK_ALL;
      2'b01:   kind_d = WK_EVEN;
      2'b10:   kind_d = WK_ODD;
      default: kind_d = WK_PAGE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q    <= '0;
      pend_q    <= 1'b0;
      blk_bit_q <= 1'b0;
      fill_q    <= 1'b0;
      lat_q     <= 1'b0;
      wdata_q   <= '0;
      page_q    <= '0;
      kind_q    <= WK_PAGE;
    end else begin
      lat_q <= cap && !blk_mode_i;
      if (cap) begin
        pend_q    <= 1'b1;
        blk_bit_q <= blk_data_i;
        if (!blk_mode_i) wdata_q <= din_i;
      end
      if (busy_o) begin
        bcnt_q <= bcnt_q - 1'b1;
      end else if (commit) begin
        bcnt_q <= BC_W'(BUSY_CYC);
        pend_q <= 1'b0;
        fill_q <= blk_mode_i;
        kind_q <= kind_d;
        page_q <= cur_page_i;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
    localparam logic [PAGE_W-1:0] PIDX = PAGE_W'(p);
    assign sel[p] = fill_q || (kind_q == WK_ALL) ||
                    ((kind_q == WK_EVEN) && !PIDX[0]) ||
                    ((kind_q == WK_ODD) && PIDX[0]) ||
                    ((kind_q == WK_PAGE) && (page_q == PIDX));
  end

  assign page_we_o  = busy_o ? sel : '0;
  assign fill_o     = busy_o && fill_q;
  assign fill_val_o = blk_bit_q;
  assign lat_we_o   = lat_q;
  assign wdata_o    = wdata_q;

  // R8
  page_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !fill_q && kind_q == WK_PAGE |-> $onehot(page_we_o));
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_fall_i) && $past(tst_i));
  // R6
  lat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_we_o |=> !lat_we_o);
  // R11
  busy_nolat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !lat_we_o);
  // R10
  fill_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |-> &page_we_o);
endmodule

// File: rtl/tmode_seq.sv
module tmode_seq #(
  parameter int ADDR_W   = 11,
  parameter int OFF_W    = 5,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 20,
  localparam int PAGE_W    = ADDR_W - OFF_W,
  localparam int NUM_PAGES = 1 << PAGE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tst_mode_i,
  input  logic                 clr_i,
  input  logic                 incr_i,
  input  logic                 strobe_i,
  input  logic                 load_i,
  input  logic                 rd_i,
  input  logic                 blk_mode_i,
  input  logic                 blk_data_i,
  input  logic                 even_sel_i,
  input  logic                 odd_sel_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    din_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 rd_en_o,
  output logic                 lat_we_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_PAGES-1:0] page_we_o,
  output logic                 fill_o,
  output logic                 fill_val_o,
  output logic                 busy_o
);
  logic [1:0] rises;
  logic       load_fall;

  tmode_seq_edge #(.W(2), .RISE(1'b1)) u_rise (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .sig_i ({strobe_i, incr_i}), .edge_o (rises)
  );

  tmode_seq_edge #(.W(1), .RISE(1'b0)) u_fall (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .sig_i (load_i), .edge_o (load_fall)
  );

  tmode_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tst_i         (tst_mode_i),
    .busy_i        (busy_o),
    .clr_i         (clr_i),
    .incr_rise_i   (rises[0]),
    .strobe_rise_i (rises[1]),
    .ext_addr_i    (addr_i),
    .addr_o        (addr_o)
  );

  tmode_seq_commit #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_commit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tst_i         (tst_mode_i),
    .load_i        (load_i),
    .strobe_rise_i (rises[1]),
    .load_fall_i   (load_fall),
    .blk_mode_i    (blk_mode_i),
    .blk_data_i    (blk_data_i),
    .even_i        (even_sel_i),
    .odd_i         (odd_sel_i),
    .din_i         (din_i),
    .cur_page_i    (addr_o[ADDR_W-1:OFF_W]),
    .lat_we_o      (lat_we_o),
    .wdata_o       (wdata_o),
    .page_we_o     (page_we_o),
    .fill_o        (fill_o),
    .fill_val_o    (fill_val_o),
    .busy_o        (busy_o)
  );

  assign rd_en_o = tst_mode_i && rd_i && !load_i && !busy_o;

  // R12
  rd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rd_en_o);
endmodule

// File: tb/tmode_seq_tb_top.sv
module tmode_seq_tb_top;
  localparam int AW = 11;
  localparam int OW = 5;
  localparam int DW = 16;
  localparam int BC = 20;
  localparam int NP = 1 << (AW - OW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tst = 0, clr = 0, incr = 0, strobe = 0, load = 0, rd = 0;
  logic blk = 0, bdat = 0, evn = 0, odd = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] addr_o;
  logic rd_en_o, lat_we_o, fill_o, fill_val_o, busy_o;
  logic [DW-1:0] wdata_o;
  logic [NP-1:0] page_we_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tst_mode_i(tst), .clr_i(clr), .incr_i(incr),
    .strobe_i(strobe), .load_i(load), .rd_i(rd), .blk_mode_i(blk),
    .blk_data_i(bdat), .even_sel_i(evn), .odd_sel_i(odd), .addr_i(addr_in),
    .din_i(din), .addr_o(addr_o), .rd_en_o(rd_en_o), .lat_we_o(lat_we_o),
    .wdata_o(wdata_o), .page_we_o(page_we_o), .fill_o(fill_o),
    .fill_val_o(fill_val_o), .busy_o(busy_o)
  );

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_areg, m_left, m_wdata;
  bit m_pend, m_lat, m_fill, m_fval, m_blkbit, ip, sp, lp;
  logic [63:0] m_mask;

  function automatic logic [63:0] mk_mask(int cnt);
    logic [63:0] m = '0;
    for (int p = 0; p < NP; p++) begin
      if (blk || (evn && odd)) m[p] = 1'b1;
      else if (evn) m[p] = (p % 2 == 0);
      else if (odd) m[p] = (p % 2 == 1);
      else m[p] = (p == (cnt >> OW));
    end
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = (1 << AW) - 1; m_areg = 0; m_left = 0; m_wdata = 0;
      m_pend = 0; m_lat = 0; m_fill = 0; m_fval = 0; m_blkbit = 0;
      ip = 0; sp = 0; lp = 0; m_mask = '0;
    end else begin
      bit bz, ir, sr, lf;
      bz = (m_left > 0);
      ir = incr && !ip; sr = strobe && !sp; lf = lp && !load;
      m_lat = 0;
      if (bz) m_left--;
      else if (tst && lf && m_pend) begin
        m_left = BC; m_pend = 0; m_fill = blk; m_fval = m_blkbit;
        m_mask = mk_mask(m_cnt);
      end
      if (tst && !bz && load && sr) begin
        m_pend = 1; m_blkbit = bdat;
        if (!blk) begin m_lat = 1; m_wdata = int'(din); end
      end
      if (tst && !bz) begin
        if (clr) m_cnt = (1 << AW) - 1;
        else if (ir) m_cnt = (m_cnt + 1) % (1 << AW);
      end
      if (!tst && sr) m_areg = int'(addr_in);
      ip = incr; sp = strobe; lp = load;
    end
    #2;
    if (rst_n) begin
      bit bz2;
      bz2 = (m_left > 0);
      cmp("R3 addr", 64'(addr_o), 64'(tst ? m_cnt : m_areg));
      cmp("R7 busy", 64'(busy_o), 64'(bz2));
      cmp("R8 page_we", 64'(page_we_o), bz2 ? m_mask : 64'd0);
      cmp("R10 fill", 64'(fill_o), 64'(bz2 && m_fill));
      if (fill_o) cmp("R10 fill_val", 64'(fill_val_o), 64'(m_fval));
      cmp("R6 lat_we", 64'(lat_we_o), 64'(m_lat));
      if (lat_we_o) cmp("R6 wdata", 64'(wdata_o), 64'(m_wdata));
      cmp("R12 rd_en", 64'(rd_en_o), 64'(tst && rd && !load && !bz2));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_incr();
    incr = 1; cyc(1); incr = 0; cyc(1);
  endtask
  task automatic pulse_strobe();
    strobe = 1; cyc(1); strobe = 0; cyc(1);
  endtask
  task automatic wait_idle();
    while (busy_o) cyc(1);
    cyc(1);
  endtask
  task automatic commit_chk(input string tag, input logic [63:0] exp);
    load = 0; cyc(1);
    cmp({tag, " busy"}, 64'(busy_o), 64'd1);
    cmp({tag, " mask"}, 64'(page_we_o), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1
    cmp("R1 busy", 64'(busy_o), 0);
    cmp("R1 page_we", 64'(page_we_o), 0);
    cmp("R1 lat_we", 64'(lat_we_o), 0);
    cmp("R1 fill", 64'(fill_o), 0);
    cmp("R1 areg", 64'(addr_o), 0);
    // R4 normal mode address register
    addr_in = 11'h123; pulse_strobe();
    cmp("R4 areg load", 64'(addr_o), 64'h123);
    pulse_incr(); clr = 1; cyc(1); clr = 0; cyc(1);
    cmp("R4 no count", 64'(addr_o), 64'h123);
    tst = 1; cyc(1);
    cmp("R1 cnt ones", 64'(addr_o), 64'h7FF);
    // R5
    addr_in = 11'h055; pulse_strobe();
    tst = 0; cyc(1);
    cmp("R5 areg kept", 64'(addr_o), 64'h123);
    tst = 1; cyc(1);
    // R2 clear beats incr
    clr = 1; incr = 1; cyc(1); clr = 0; incr = 0; cyc(1);
    cmp("R2 clear wins", 64'(addr_o), 64'h7FF);
    pulse_incr();
    cmp("R3 wrap to 0", 64'(addr_o), 0);
    incr = 1; cyc(3); incr = 0; cyc(1);
    cmp("R3 held once", 64'(addr_o), 1);
    // page write
    clr = 1; cyc(1); clr = 0; cyc(1);
    load = 1; cyc(1);
    for (int k = 0; k < 4; k++) begin
      pulse_incr();
      din = 16'hA0 + 16'(k);
      strobe = 1; cyc(1);
      cmp("R6 lat pulse", 64'(lat_we_o), 1);
      cmp("R6 wdata", 64'(wdata_o), 64'(16'hA0 + 16'(k)));
      strobe = 0; cyc(1);
      cmp("R6 lat single", 64'(lat_we_o), 0);
    end
    commit_chk("R8 page0", 64'h1);
    n = 1;
    incr = 1; cyc(1); n += int'(busy_o);
    incr = 0; clr = 1; load = 1; strobe = 1; cyc(1); n += int'(busy_o);
    clr = 0; strobe = 0; load = 0; cyc(1); n += int'(busy_o);
    cmp("R11 cnt held", 64'(addr_o), 3);
    cmp("R11 no lat", 64'(lat_we_o), 0);
    while (busy_o) begin cyc(1); n += int'(busy_o); end
    cmp("R7 busy length", 64'(n), 64'(BC));
    cyc(1);
    // R7 load fall without capture
    load = 1; cyc(2); load = 0; cyc(2);
    cmp("R7 no arm no write", 64'(busy_o), 0);
    // advance to page 1 (0x20)
    for (int k = 0; k < 29; k++) pulse_incr();
    cmp("R3 count 0x20", 64'(addr_o), 64'h20);
    // R9 even / odd / both
    evn = 1; load = 1; din = 16'h1111; pulse_strobe();
    commit_chk("R9 even", 64'h5555_5555_5555_5555); wait_idle();
    evn = 0; odd = 1; load = 1; pulse_strobe();
    commit_chk("R9 odd", 64'hAAAA_AAAA_AAAA_AAAA); wait_idle();
    evn = 1; load = 1; pulse_strobe();
    commit_chk("R9 both", '1); wait_idle();
    evn = 0; odd = 0; load = 1; pulse_strobe();
    commit_chk("R8 page1", 64'h2); wait_idle();
    // R10 block fill
    blk = 1; bdat = 1; odd = 1; load = 1; strobe = 1; cyc(1);
    cmp("R10 no lat", 64'(lat_we_o), 0);
    strobe = 0; cyc(1);
    commit_chk("R10 fill1", '1);
    cmp("R10 fill", 64'(fill_o), 1);
    cmp("R10 val1", 64'(fill_val_o), 1);
    wait_idle();
    bdat = 0; odd = 0; load = 1; pulse_strobe();
    commit_chk("R10 fill0", '1);
    cmp("R10 val0", 64'(fill_val_o), 0);
    wait_idle();
    blk = 0;
    // R12 read enable
    rd = 1; cyc(1);
    cmp("R12 rd on", 64'(rd_en_o), 1);
    load = 1; cyc(1);
    cmp("R12 rd load", 64'(rd_en_o), 0);
    load = 0; tst = 0; cyc(1);
    cmp("R12 rd no tst", 64'(rd_en_o), 0);
    rd = 0; cyc(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule